// File: doc/BRIEF.md
# NAND Command Interface Decoder

This block models the command side of a byte-wide NAND memory. A host drives a shared 8-bit bus with a write strobe, a read strobe, a chip select and two latch enables. The block samples these pins on the system clock and finds the strobe edges itself. On each rising write strobe it classifies the cycle as a command, an address or a data byte. It tracks one- and two-cycle opcode sequences and fills column and row registers from the address cycles. It holds a small behavioural page array with a page buffer in front of it, and it drives ready/busy from one down-counter that is loaded with parameter-set cycle counts.

On each falling read strobe the block presents one byte: data, status or identification. In data and identification mode the column pointer then advances. The array holds NPAGE pages of PBYTES bytes, grouped into erase blocks of PPB pages. It is sized for simulation and is meant to stand in for a real device in controller test benches.

Top module: `nand_cmd_front`

## Requirements
- R1: A cycle counts only when chip select (ce_ni) is low at the rising write strobe. It is a command when cle_i=1 and ale_i=0, an address when ale_i=1 and cle_i=0, and data when both are 0. With ce_ni high the strobe has no effect. An opcode outside the supported set starts no busy period and drops any pending setup, so a later confirm opcode is ignored.
- R2: After reset, rb_o is 1 and read setup (00h) is already latched. Five address cycles followed by 30h copy the addressed page into the buffer and hold rb_o low for exactly T_READ clock cycles, counted from the first clock after the strobe edge is seen.
- R3: Read and program use five address cycles: column bits 7:0, then column bits 11:8 (bits 3:0 of the second cycle), then three row cycles. The page index is taken from the low bits of the third cycle. Address cycles beyond the count the current operation needs are ignored.
- R4: Each falling read strobe with ce_ni low puts the byte at the current column on dq_o and advances the column by one. Output starts at the column given with the read.
- R5: 80h fills the buffer with FFh. Data cycles then write bytes at the column and advance it. 10h stores the buffer into the addressed page with rb_o low for T_PROG cycles. 15h does the same with rb_o low for T_CACHE cycles, and afterwards sets status bit 5.
- R6: A 10h confirm with no data cycle since the setup starts no busy period and leaves the page unchanged.
- R7: While rb_o is 0, only 70h and FFh are acted on. Every other opcode is ignored.
- R8: The status byte is {wp_ni, ready, cache-done, 0000, fail}. After 70h every read returns status and leaves the column unchanged, until 00h returns output to data at the unchanged column.
- R9: FFh holds rb_o low for T_RST cycles, clears the fail and cache-done bits, and latches read setup. With wp_ni high the status then reads C0h.
- R10: 05h, two column cycles and E0h move the output column. Inside a program load, 85h and two column cycles move the input column.
- R11: 00h, five address cycles and 35h load a page. Then 85h, five address cycles and 10h store the buffer into the new page without any data cycle.
- R12: 60h, three row cycles and D0h set every page of the addressed block to FFh, with rb_o low for T_ERASE cycles.
- R13: With wp_ni low, a program or erase confirm leaves the array unchanged, starts no busy period and sets status bit 0.
- R14: 90h and one address cycle switch output to identification. Successive reads return the bytes of ID_WORD, least significant byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| we_ni | input | 1 | Write strobe, active low, sampled on its rising edge |
| re_ni | input | 1 | Read strobe, active low, acts on its falling edge |
| wp_ni | input | 1 | Write protect, active low |
| dq_i | input | 8 | Bus value driven by the host |
| dq_o | output | 8 | Byte presented on a read strobe |
| dq_oe_o | output | 1 | Output enable for dq_o |
| rb_o | output | 1 | Ready (1) / busy (0) |

## Verification
The bench goes after the sequencing corners. A program confirm with no data cycle must not go busy; a design that ignores the data-loaded flag would stall and write an all-FFh page. A status read must not move the column, so a read that continues after 00h must resume at the next unread byte rather than skip one. Extra address cycles and a six-cycle read check that the address count saturates; an erase issued while busy checks that the second opcode is not taken as a valid confirm. Copy-back, random column moves, write protection and a run of randomly placed programs are compared against a bench page model, and every busy period is counted to the exact cycle.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

  typedef enum logic [2:0] {
    C_IDLE, C_READ, C_PROG, C_RNDIN, C_COPY, C_ERASE, C_RNDOUT, C_ID
  } cmd_e;

  typedef enum logic [1:0] {O_DATA, O_STAT, O_ID} out_e;

  localparam logic [7:0] OP_RD0 = 8'h00;
  localparam logic [7:0] OP_RD1 = 8'h30;
  localparam logic [7:0] OP_CPR = 8'h35;
  localparam logic [7:0] OP_PG0 = 8'h80;
  localparam logic [7:0] OP_PG1 = 8'h10;
  localparam logic [7:0] OP_CCH = 8'h15;
  localparam logic [7:0] OP_CPW = 8'h85;
  localparam logic [7:0] OP_ER0 = 8'h60;
  localparam logic [7:0] OP_ER1 = 8'hD0;
  localparam logic [7:0] OP_RO0 = 8'h05;
  localparam logic [7:0] OP_RO1 = 8'hE0;
  localparam logic [7:0] OP_STS = 8'h70;
  localparam logic [7:0] OP_IDR = 8'h90;
  localparam logic [7:0] OP_RST = 8'hFF;

  // address cycles each setup expects
  function automatic logic [2:0] addr_need(cmd_e c);
    case (c)
      C_READ, C_PROG, C_COPY: return 3'd5;
      C_ERASE:                return 3'd3;
      C_RNDIN, C_RNDOUT:      return 3'd2;
      C_ID:                   return 3'd1;
      default:                return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge #(
  parameter bit RISE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic edge_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= 1'b1;
    else         q <= strobe_i;

  generate
    if (RISE) begin : g_rise
      assign edge_o = ~q & strobe_i;
    end else begin : g_fall
      assign edge_o = q & ~strobe_i;
    end
  endgenerate
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] len_i,
  output logic          rdy_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= len_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;

  assign rdy_o = (cnt_q == '0);

  // R2
  busy_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nand_page_store.sv
module nand_page_store #(
  parameter  int NPAGE  = 8,
  parameter  int PBYTES = 16,
  parameter  int PPB    = 4,
  localparam int PGW    = $clog2(NPAGE),
  localparam int IXW    = $clog2(PBYTES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [PGW-1:0] pg_i,
  input  logic           clr_i,
  input  logic           load_i,
  input  logic           prog_i,
  input  logic           erase_i,
  input  logic           wr_en_i,
  input  logic [IXW-1:0] wr_idx_i,
  input  logic [7:0]     wr_data_i,
  input  logic [IXW-1:0] rd_idx_i,
  output logic [7:0]     rd_data_o
);
  localparam int BKS = $clog2(PPB);

  logic [7:0] mem_q [NPAGE][PBYTES];
  logic [7:0] buf_q [PBYTES];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int p = 0; p < NPAGE; p++)
        for (int b = 0; b < PBYTES; b++) mem_q[p][b] <= 8'hFF;
    end else begin
      for (int p = 0; p < NPAGE; p++) begin
        if (prog_i && pg_i == PGW'(p)) begin
          for (int b = 0; b < PBYTES; b++) mem_q[p][b] <= buf_q[b];
        end else if (erase_i && (PGW'(p) >> BKS) == (pg_i >> BKS)) begin
          for (int b = 0; b < PBYTES; b++) mem_q[p][b] <= 8'hFF;
        end
      end
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int b = 0; b < PBYTES; b++) buf_q[b] <= 8'hFF;
    end else if (clr_i) begin
      for (int b = 0; b < PBYTES; b++) buf_q[b] <= 8'hFF;
    end else if (load_i) begin
      for (int b = 0; b < PBYTES; b++) buf_q[b] <= mem_q[pg_i][b];
    end else if (wr_en_i) begin
      buf_q[wr_idx_i] <= wr_data_i;
    end

  assign rd_data_o = buf_q[rd_idx_i];

  // R5
  buf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (buf_q[0] == 8'hFF && buf_q[PBYTES-1] == 8'hFF));
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_cmd_pkg::*;
#(
  parameter int          NPAGE   = 8,
  parameter int          PBYTES  = 16,
  parameter int          PPB     = 4,
  parameter int          T_READ  = 20,
  parameter int          T_PROG  = 40,
  parameter int          T_CACHE = 8,
  parameter int          T_ERASE = 60,
  parameter int          T_RST   = 5,
  parameter logic [31:0] ID_WORD = 32'hA5C3_005A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_ni,
  input  logic       re_ni,
  input  logic       wp_ni,
  input  logic [7:0] dq_i,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  output logic       rb_o
);
  localparam int PGW = $clog2(NPAGE);
  localparam int IXW = $clog2(PBYTES);
  localparam int TW  = $clog2(T_READ + T_PROG + T_CACHE + T_ERASE + T_RST + 1);

  logic we_rise, re_fall, rdy, busy;
  logic cyc_cmd, cyc_addr, cyc_data, is_load, addr_done;
  logic [2:0] need, phase;

  cmd_e       cmd_q, cmd_d;
  out_e       mode_q, mode_d;
  logic [2:0] acnt_q, acnt_d;
  logic [11:0] col_q, col_d, colp_q, colp_d;
  logic [PGW-1:0] row_q, row_d;
  logic loaded_q, loaded_d, fail_q, fail_d, cache_q, cache_d;

  logic t_start;
  logic [TW-1:0] t_len;
  logic buf_clr, buf_ld, buf_wr, arr_pg, arr_er;
  logic [7:0] rd_data, stat_byte, out_byte;

  nand_strobe_edge #(.RISE(1'b1)) u_we (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(we_ni), .edge_o(we_rise));
  nand_strobe_edge #(.RISE(1'b0)) u_re (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(re_ni), .edge_o(re_fall));

  nand_busy_timer #(.TW(TW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(t_start), .len_i(t_len), .rdy_o(rdy));

  nand_page_store #(.NPAGE(NPAGE), .PBYTES(PBYTES), .PPB(PPB)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .pg_i(row_q),
    .clr_i(buf_clr), .load_i(buf_ld), .prog_i(arr_pg), .erase_i(arr_er),
    .wr_en_i(buf_wr), .wr_idx_i(col_q[IXW-1:0]), .wr_data_i(dq_i),
    .rd_idx_i(col_q[IXW-1:0]), .rd_data_o(rd_data));

  assign busy      = ~rdy;
  assign cyc_cmd   = we_rise & ~ce_ni &  cle_i & ~ale_i;
  assign cyc_addr  = we_rise & ~ce_ni &  ale_i & ~cle_i;
  assign cyc_data  = we_rise & ~ce_ni & ~ale_i & ~cle_i;
  assign is_load   = (cmd_q == C_PROG) || (cmd_q == C_RNDIN) || (cmd_q == C_COPY);
  assign need      = addr_need(cmd_q);
  assign addr_done = (acnt_q == need);
  assign phase     = (cmd_q == C_ERASE) ? acnt_q + 3'd2 : acnt_q;

  always_comb begin
    cmd_d = cmd_q;   acnt_d = acnt_q;   mode_d = mode_q;
    col_d = col_q;   colp_d = colp_q;   row_d  = row_q;
    loaded_d = loaded_q; fail_d = fail_q; cache_d = cache_q;
    t_start = 1'b0; t_len = '0;
    buf_clr = 1'b0; buf_ld = 1'b0; buf_wr = 1'b0; arr_pg = 1'b0; arr_er = 1'b0;

    if (cyc_cmd) begin
      if (busy) begin
        if (dq_i == OP_STS) mode_d = O_STAT;
        else if (dq_i == OP_RST) begin
          cmd_d = C_READ; acnt_d = '0; mode_d = O_DATA;
          fail_d = 1'b0; cache_d = 1'b0;
          t_start = 1'b1; t_len = TW'(T_RST);
        end
      end else begin
        cmd_d = C_IDLE;
        acnt_d = '0;
        case (dq_i)
          OP_RD0: begin cmd_d = C_READ; mode_d = O_DATA; end
          OP_RD1, OP_CPR: begin
            if (cmd_q == C_READ && addr_done) begin
              buf_ld = 1'b1; col_d = colp_q; mode_d = O_DATA;
              t_start = 1'b1; t_len = TW'(T_READ);
            end
          end
          OP_PG0: begin cmd_d = C_PROG; buf_clr = 1'b1; loaded_d = 1'b0; end
          OP_CPW: begin
            if (is_load && addr_done) cmd_d = C_RNDIN;
            else begin cmd_d = C_COPY; loaded_d = 1'b1; end
          end
          OP_PG1, OP_CCH: begin
            if (is_load && addr_done && loaded_q) begin
              if (!wp_ni) fail_d = 1'b1;
              else begin
                arr_pg = 1'b1; fail_d = 1'b0; t_start = 1'b1;
                cache_d = (dq_i == OP_CCH);
                t_len = (dq_i == OP_CCH) ? TW'(T_CACHE) : TW'(T_PROG);
              end
            end
          end
          OP_ER0: cmd_d = C_ERASE;
          OP_ER1: begin
            if (cmd_q == C_ERASE && addr_done) begin
              if (!wp_ni) fail_d = 1'b1;
              else begin
                arr_er = 1'b1; fail_d = 1'b0; cache_d = 1'b0;
                t_start = 1'b1; t_len = TW'(T_ERASE);
              end
            end
          end
          OP_RO0: cmd_d = C_RNDOUT;
          OP_RO1: if (cmd_q == C_RNDOUT && addr_done) begin
            col_d = colp_q; mode_d = O_DATA;
          end
          OP_STS: begin cmd_d = cmd_q; acnt_d = acnt_q; mode_d = O_STAT; end
          OP_IDR: begin cmd_d = C_ID; mode_d = O_ID; col_d = '0; end
          OP_RST: begin
            cmd_d = C_READ; mode_d = O_DATA; fail_d = 1'b0; cache_d = 1'b0;
            t_start = 1'b1; t_len = TW'(T_RST);
          end
          default: ;
        endcase
      end
    end else if (cyc_addr) begin
      if (!busy && acnt_q < need) begin
        acnt_d = acnt_q + 3'd1;
        if (cmd_q != C_ID) begin
          case (phase)
            3'd0: colp_d[7:0] = dq_i;
            3'd1: begin
              colp_d[11:8] = dq_i[3:0];
              if (is_load) col_d = {dq_i[3:0], colp_q[7:0]};
            end
            3'd2: row_d = dq_i[PGW-1:0];
            default: ;  // upper row cycles exceed the modelled array
          endcase
        end
      end
    end else if (cyc_data) begin
      if (!busy && is_load && addr_done) begin
        buf_wr = 1'b1; col_d = col_q + 12'd1; loaded_d = 1'b1;
      end
    end else if (re_fall && !ce_ni && mode_q != O_STAT) begin
      col_d = col_q + 12'd1;
    end
  end

  assign stat_byte = {wp_ni, rdy, cache_q & rdy, 4'b0000, fail_q};

  always_comb
    case (mode_q)
      O_STAT:  out_byte = stat_byte;
      O_ID:    out_byte = ID_WORD[8*col_q[1:0] +: 8];
      default: out_byte = rd_data;
    endcase

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cmd_q <= C_READ; acnt_q <= '0; mode_q <= O_DATA;
      col_q <= '0; colp_q <= '0; row_q <= '0;
      loaded_q <= 1'b0; fail_q <= 1'b0; cache_q <= 1'b0;
      dq_o <= 8'h00;
    end else begin
      cmd_q <= cmd_d; acnt_q <= acnt_d; mode_q <= mode_d;
      col_q <= col_d; colp_q <= colp_d; row_q <= row_d;
      loaded_q <= loaded_d; fail_q <= fail_d; cache_q <= cache_d;
      if (re_fall && !ce_ni) dq_o <= out_byte;
    end

  assign dq_oe_o = ~ce_ni & ~re_ni;
  assign rb_o    = rdy;

  // R7
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cyc_cmd && dq_i != OP_STS && dq_i != OP_RST)
      |=> ($stable(cmd_q) && $stable(acnt_q) && $stable(mode_q)));

  // R3
  addr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acnt_q <= 3'd5);

  // R4
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_fall && !ce_ni && !we_rise && mode_q != O_STAT) |=> (col_q == $past(col_q) + 12'd1));

  // R6
  empty_prog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && cyc_cmd && dq_i == OP_PG1 && !loaded_q) |=> rb_o);
endmodule

// File: tb/sim_nand_cmd_front.sv
module sim_nand_cmd_front;
  localparam int T_READ = 20, T_PROG = 40, T_CACHE = 8, T_ERASE = 60, T_RST = 5;
  localparam logic [31:0] IDW = 32'hA5C3_005A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] dq = 8'h00;
  logic [7:0] dq_o;
  logic dq_oe, rb;

  int n_vec = 0, n_bad = 0;
  logic [7:0] mdl [8][16];

  always #10 clk = ~clk;

  nand_cmd_front #(.T_READ(T_READ), .T_PROG(T_PROG), .T_CACHE(T_CACHE),
                   .T_ERASE(T_ERASE), .T_RST(T_RST), .ID_WORD(IDW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .we_ni(we_n), .re_ni(re_n), .wp_ni(wp_n), .dq_i(dq),
    .dq_o(dq_o), .dq_oe_o(dq_oe), .rb_o(rb));

  function automatic logic [7:0] stat_exp(logic wp, logic rdy, logic cdone, logic fail);
    return {wp, rdy, cdone & rdy, 4'b0000, fail};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic a, input logic [7:0] d, input logic ce_hi = 1'b0);
    @(negedge clk); ce_n = ce_hi; cle = c; ale = a; dq = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  task automatic confirm(input logic [7:0] op, output int lows);
    @(negedge clk); ce_n = 1'b0; cle = 1'b1; ale = 1'b0; dq = op; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    lows = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (!rb) lows++; else break;
    end
    cle = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); v = dq_o; re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic addr5(input int col, input int pg);
    bus_wr(0, 1, 8'(col)); bus_wr(0, 1, 8'(col >> 8));
    bus_wr(0, 1, 8'(pg));  bus_wr(0, 1, 8'h00); bus_wr(0, 1, 8'h00);
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 2000 && !rb; k++) @(negedge clk);
  endtask

  task automatic read_page(input int pg, input string tag);
    int l; logic [7:0] v;
    bus_wr(1, 0, 8'h00); addr5(0, pg); confirm(8'h30, l);
    check({tag, " read busy"}, l, T_READ);
    for (int b = 0; b < 16; b++) begin
      rd(v); check({tag, " page byte"}, v, mdl[pg][b]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int l; logic [7:0] v; logic [7:0] dat [16]; logic [7:0] x0, x1, x2;
    void'($urandom(32'd1357));
    for (int p = 0; p < 8; p++) for (int b = 0; b < 16; b++) mdl[p][b] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; ce_n = 1'b0;
    @(negedge clk);
    check("R2 reset ready", rb, 1);
    check("R4 oe idle", dq_oe, 0);

    // R9 reset command
    confirm(8'hFF, l); check("R9 reset busy", l, T_RST);
    bus_wr(1, 0, 8'h70); rd(v); check("R9 status after reset", v, 8'hC0);
    rd(v); check("R8 status repeats", v, 8'hC0);

    // R5 program page 1
    bus_wr(1, 0, 8'h80); addr5(0, 1);
    for (int b = 0; b < 16; b++) begin
      dat[b] = 8'($urandom); bus_wr(0, 0, dat[b]); mdl[1][b] = dat[b];
    end
    confirm(8'h10, l); check("R5 program busy", l, T_PROG);

    // R2 R4 read back start of page 1
    bus_wr(1, 0, 8'h00); addr5(0, 1); confirm(8'h30, l);
    check("R2 read busy", l, T_READ);
    for (int b = 0; b < 4; b++) begin rd(v); check("R4 sequential", v, mdl[1][b]); end
    // R8 status leaves column, 00h resumes
    bus_wr(1, 0, 8'h70); rd(v); check("R8 status", v, 8'hC0);
    bus_wr(1, 0, 8'h00); rd(v); check("R8 resume column", v, mdl[1][4]);

    // R3 start column, ignored bits, extra cycle
    bus_wr(1, 0, 8'h00);
    bus_wr(0, 1, 8'h05); bus_wr(0, 1, 8'hF0); bus_wr(0, 1, 8'h01);
    bus_wr(0, 1, 8'h00); bus_wr(0, 1, 8'hFE); bus_wr(0, 1, 8'h07);
    confirm(8'h30, l); check("R3 read busy", l, T_READ);
    rd(v); check("R3 start column", v, mdl[1][5]);
    rd(v); check("R3 next column", v, mdl[1][6]);

    // R10 random output column
    bus_wr(1, 0, 8'h05); bus_wr(0, 1, 8'h0C); bus_wr(0, 1, 8'h00); bus_wr(1, 0, 8'hE0);
    rd(v); check("R10 random out", v, mdl[1][12]);

    // R7 R8 program page 2, commands during busy
    bus_wr(1, 0, 8'h80); addr5(0, 2);
    for (int b = 0; b < 16; b++) begin
      dat[b] = 8'($urandom); bus_wr(0, 0, dat[b]); mdl[2][b] = dat[b];
    end
    bus_wr(1, 0, 8'h10);
    bus_wr(1, 0, 8'h70); rd(v); check("R8 status busy", v, 8'h80);
    bus_wr(1, 0, 8'h60);
    wait_ready();
    confirm(8'hD0, l); check("R7 erase setup ignored while busy", l, 0);
    read_page(2, "R7");

    // R6 confirm with no data
    bus_wr(1, 0, 8'h80); addr5(0, 3); confirm(8'h10, l);
    check("R6 no busy", l, 0);
    read_page(3, "R6");

    // R10 random data input
    x0 = 8'($urandom); x1 = 8'($urandom); x2 = 8'($urandom);
    bus_wr(1, 0, 8'h80); addr5(0, 3);
    bus_wr(0, 0, x0); bus_wr(0, 0, x1);
    bus_wr(1, 0, 8'h85); bus_wr(0, 1, 8'h08); bus_wr(0, 1, 8'h00);
    bus_wr(0, 0, x2);
    confirm(8'h10, l); check("R10 program busy", l, T_PROG);
    mdl[3][0] = x0; mdl[3][1] = x1; mdl[3][8] = x2;
    read_page(3, "R10");

    // R11 copy-back page 1 -> page 4
    bus_wr(1, 0, 8'h00); addr5(0, 1); confirm(8'h35, l);
    check("R11 copy read busy", l, T_READ);
    bus_wr(1, 0, 8'h85); addr5(0, 4); confirm(8'h10, l);
    check("R11 copy program busy", l, T_PROG);
    for (int b = 0; b < 16; b++) mdl[4][b] = mdl[1][b];
    read_page(4, "R11");

    // R12 erase block 0 (pages 0..3)
    bus_wr(1, 0, 8'h60); bus_wr(0, 1, 8'h01); bus_wr(0, 1, 8'h00); bus_wr(0, 1, 8'h00);
    confirm(8'hD0, l); check("R12 erase busy", l, T_ERASE);
    for (int p = 0; p < 4; p++) for (int b = 0; b < 16; b++) mdl[p][b] = 8'hFF;
    read_page(2, "R12");
    read_page(4, "R12 other block");

    // R13 write protect
    wp_n = 1'b0;
    bus_wr(1, 0, 8'h80); addr5(0, 5); bus_wr(0, 0, 8'h3C);
    confirm(8'h10, l); check("R13 no busy", l, 0);
    bus_wr(1, 0, 8'h70); rd(v); check("R13 fail status", v, stat_exp(0, 1, 0, 1));
    wp_n = 1'b1;

    // R1 command ignored with chip select high
    bus_wr(1, 0, 8'h00, 1'b1);
    rd(v); check("R1 ce high ignored", v, stat_exp(1, 1, 0, 1));
    read_page(5, "R13");
    // R1 undefined opcode drops the read setup
    bus_wr(1, 0, 8'h00); addr5(0, 4);
    confirm(8'h3A, l); check("R1 undefined no busy", l, 0);
    confirm(8'h30, l); check("R1 confirm after undefined", l, 0);

    // R14 identification
    bus_wr(1, 0, 8'h90); bus_wr(0, 1, 8'h00);
    for (int k = 0; k < 4; k++) begin
      rd(v); check("R14 id byte", v, IDW[8*k +: 8]);
    end

    // R5 cache program
    bus_wr(1, 0, 8'h80); addr5(0, 6);
    for (int b = 0; b < 16; b++) mdl[6][b] = 8'hFF;
    for (int b = 0; b < 3; b++) begin
      dat[b] = 8'($urandom); bus_wr(0, 0, dat[b]); mdl[6][b] = dat[b];
    end
    confirm(8'h15, l); check("R5 cache busy", l, T_CACHE);
    bus_wr(1, 0, 8'h70); rd(v); check("R5 cache status", v, stat_exp(1, 1, 1, 0));
    read_page(6, "R5 cache");

    // R5 R3 random placed programs in block 1
    for (int it = 0; it < 6; it++) begin
      int pg, sc, nb;
      pg = 4 + int'($urandom % 4);
      sc = int'($urandom % 8);
      nb = 1 + int'($urandom % 8);
      for (int b = 0; b < 16; b++) mdl[pg][b] = 8'hFF;
      bus_wr(1, 0, 8'h80); addr5(sc, pg);
      for (int b = 0; b < nb; b++) begin
        v = 8'($urandom); bus_wr(0, 0, v); mdl[pg][sc + b] = v;
      end
      confirm(8'h10, l); check("R5 random program busy", l, T_PROG);
      read_page(pg, "R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule